// File: doc/BRIEF.md
# Lazy-Copy Page Migration Sequencer

This block controls one page migration between memory controllers. It watches a load figure from each controller. When the spread between the busiest and the idlest controller grows past a programmable margin, it starts a migration. First it picks the busiest controller as the donor. It then asks an external cost selector which controller should receive the pages. After that it works through a fixed series of commands: mark the pages read-only, copy each page, flush the dirty lines, and publish the new translations.

Copying is lazy. The pages stay readable at their old location until every copy has finished, and the translation switch is the last command issued. A write that lands on a page that is read-only while the copy is running raises a stall. The stall clears once the translation update has been acknowledged. Every command port uses a valid/ready handshake followed by a done pulse. The copy engine, cache flush logic and translation tables sit outside this block.

Top module: `mig_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `stall_o`, `rcp_req_valid_o` and all four command valids are 0.
- R2: A migration starts from idle only when the maximum load minus the minimum load is strictly greater than `thresh_i` and `npages_i` is nonzero. `busy_o` rises one cycle after the triggering inputs are present.
- R3: The donor is the controller with the highest load, and the lowest index wins a tie. Controller k's load is `load_i[k*LOAD_W +: LOAD_W]`. The donor is offered on `rcp_req_donor_o` while `rcp_req_valid_o` is high, and the recipient id is taken in the cycle `rcp_rsp_valid_i` is high.
- R4: Commands appear strictly in this order: mark read-only, then copies, then flush, then translation update. At most one request valid is high at any time.
- R5: Exactly N copy commands are issued, with `cp_page_o` running 0 to N-1. N is the value of `npages_i` sampled when the migration starts, and later changes to `npages_i` are ignored.
- R6: A command valid stays high until ready is seen. A done pulse that arrives before ready has been accepted is ignored. The sequencer does not move on until done arrives after acceptance.
- R7: No translation-update valid is raised before the done of the last copy.
- R8: A write hit (`wr_hit_i`) during the copy, flush or translation-update phases sets `stall_o` on the next cycle. `stall_o` stays high until the translation-update done is accepted. A write hit in any other phase has no effect.
- R9: `busy_o` is high from the cycle after the start until the end of the single cycle in which `done_o` pulses. `done_o` pulses one cycle after the translation-update done.
- R10: `cmd_donor_o` and `cmd_rcp_o` carry the latched donor and recipient ids. `cmd_count_o` carries the latched N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | NUM_MC*LOAD_W | Load per controller, packed by index |
| thresh_i | input | LOAD_W | Imbalance margin |
| npages_i | input | PG_W | Pages moved per migration |
| wr_hit_i | input | 1 | A write hit a page under migration |
| rcp_req_valid_o | output | 1 | Recipient selection request |
| rcp_req_donor_o | output | ID_W | Donor id for the selector |
| rcp_rsp_valid_i | input | 1 | Recipient response valid |
| rcp_rsp_id_i | input | ID_W | Chosen recipient id |
| ro_valid_o | output | 1 | Mark read-only command valid |
| ro_ready_i | input | 1 | Mark read-only accepted |
| ro_done_i | input | 1 | Mark read-only complete |
| cp_valid_o | output | 1 | Page copy command valid |
| cp_ready_i | input | 1 | Page copy accepted |
| cp_done_i | input | 1 | Page copy complete |
| cp_page_o | output | PG_W | Page index being copied |
| fl_valid_o | output | 1 | Dirty line flush command valid |
| fl_ready_i | input | 1 | Flush accepted |
| fl_done_i | input | 1 | Flush complete |
| tlb_valid_o | output | 1 | Translation update command valid |
| tlb_ready_i | input | 1 | Translation update accepted |
| tlb_done_i | input | 1 | Translation update complete |
| cmd_donor_o | output | ID_W | Latched donor id |
| cmd_rcp_o | output | ID_W | Latched recipient id |
| cmd_count_o | output | PG_W | Latched page count |
| stall_o | output | 1 | Writers must stall |
| busy_o | output | 1 | Migration in progress |
| done_o | output | 1 | Migration finished (one-cycle pulse) |

## Verification
The first timed result is `busy_o`, which is due one cycle after the loads cross the margin. The recipient request follows one cycle after that. Each command valid drops one cycle after its ready, and the next valid or `done_o` appears one cycle after the done pulse. `stall_o` follows a write hit by one cycle. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands in exactly the cycle that the register count above predicts. Handshakes wait on the observed valid, with a bounded poll.

// File: rtl/mig_pkg.sv
package mig_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK_DONOR, ST_PICK_RCP, ST_MARK_RO,
    ST_COPY, ST_FLUSH, ST_TLB, ST_DONE
  } mig_state_e;

  localparam int NUM_CMD = 4;
  localparam int CMD_RO  = 0;
  localparam int CMD_CP  = 1;
  localparam int CMD_FL  = 2;
  localparam int CMD_TLB = 3;

  function automatic mig_state_e cmd_state(input int idx);
    case (idx)
      CMD_RO:  return ST_MARK_RO;
      CMD_CP:  return ST_COPY;
      CMD_FL:  return ST_FLUSH;
      default: return ST_TLB;
    endcase
  endfunction
endpackage

// File: rtl/mig_load_scan.sv
module mig_load_scan #(
  parameter int NUM_MC = 4,
  parameter int LOAD_W = 8,
  parameter int ID_W   = 2
) (
  input  logic [NUM_MC*LOAD_W-1:0] load_i,
  output logic [ID_W-1:0]          max_id_o,
  output logic [LOAD_W-1:0]        max_o,
  output logic [LOAD_W-1:0]        min_o
);
  always_comb begin
    max_id_o = '0;
    max_o    = load_i[LOAD_W-1:0];
    min_o    = load_i[LOAD_W-1:0];
    for (int k = 1; k < NUM_MC; k++) begin
      // strict compare keeps the lowest index on a tie
      if (load_i[k*LOAD_W +: LOAD_W] > max_o) begin
        max_o    = load_i[k*LOAD_W +: LOAD_W];
        max_id_o = ID_W'(k);
      end
      if (load_i[k*LOAD_W +: LOAD_W] < min_o) min_o = load_i[k*LOAD_W +: LOAD_W];
    end
  end
endmodule

// File: rtl/mig_cmd_port.sv
module mig_cmd_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic ready_i,
  input  logic done_i,
  output logic valid_o,
  output logic finish_o
);
  logic sent_q;

  assign valid_o  = active_i && !sent_q;
  assign finish_o = active_i && sent_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sent_q <= 1'b0;
    else if (!active_i || finish_o) sent_q <= 1'b0;
    else if (valid_o && ready_i)  sent_q <= 1'b1;
  end
endmodule

// File: rtl/mig_seq.sv
module mig_seq
  import mig_pkg::*;
#(
  parameter int NUM_MC = 4,
  parameter int LOAD_W = 8,
  parameter int PG_W   = 4,
  localparam int ID_W  = (NUM_MC > 1) ? $clog2(NUM_MC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_MC*LOAD_W-1:0] load_i,
  input  logic [LOAD_W-1:0]        thresh_i,
  input  logic [PG_W-1:0]          npages_i,
  input  logic                     wr_hit_i,
  output logic                     rcp_req_valid_o,
  output logic [ID_W-1:0]          rcp_req_donor_o,
  input  logic                     rcp_rsp_valid_i,
  input  logic [ID_W-1:0]          rcp_rsp_id_i,
  output logic                     ro_valid_o,
  input  logic                     ro_ready_i,
  input  logic                     ro_done_i,
  output logic                     cp_valid_o,
  input  logic                     cp_ready_i,
  input  logic                     cp_done_i,
  output logic [PG_W-1:0]          cp_page_o,
  output logic                     fl_valid_o,
  input  logic                     fl_ready_i,
  input  logic                     fl_done_i,
  output logic                     tlb_valid_o,
  input  logic                     tlb_ready_i,
  input  logic                     tlb_done_i,
  output logic [ID_W-1:0]          cmd_donor_o,
  output logic [ID_W-1:0]          cmd_rcp_o,
  output logic [PG_W-1:0]          cmd_count_o,
  output logic                     stall_o,
  output logic                     busy_o,
  output logic                     done_o
);
  mig_state_e        state_q, state_d;
  logic [ID_W-1:0]   donor_q, rcp_q;
  logic [PG_W-1:0]   n_q, pg_q;
  logic              stall_q;
  logic [ID_W-1:0]   max_id;
  logic [LOAD_W-1:0] max_v, min_v;
  logic              start_ok, last_pg, ro_window;

  logic [NUM_CMD-1:0] c_act, c_rdy, c_done, c_vld, c_fin;

  mig_load_scan #(.NUM_MC(NUM_MC), .LOAD_W(LOAD_W), .ID_W(ID_W)) i_scan (
    .load_i   (load_i),
    .max_id_o (max_id),
    .max_o    (max_v),
    .min_o    (min_v)
  );

  assign c_rdy  = {tlb_ready_i, fl_ready_i, cp_ready_i, ro_ready_i};
  assign c_done = {tlb_done_i, fl_done_i, cp_done_i, ro_done_i};

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    assign c_act[g] = (state_q == cmd_state(g));
    mig_cmd_port i_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (c_act[g]),
      .ready_i  (c_rdy[g]),
      .done_i   (c_done[g]),
      .valid_o  (c_vld[g]),
      .finish_o (c_fin[g])
    );
  end

  assign start_ok  = ((max_v - min_v) > thresh_i) && (npages_i != '0);
  assign last_pg   = (pg_q == n_q - PG_W'(1));
  assign ro_window = (state_q == ST_COPY) || (state_q == ST_FLUSH) || (state_q == ST_TLB);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start_ok) state_d = ST_PICK_DONOR;
      ST_PICK_DONOR: state_d = ST_PICK_RCP;
      ST_PICK_RCP:   if (rcp_rsp_valid_i) state_d = ST_MARK_RO;
      ST_MARK_RO:    if (c_fin[CMD_RO]) state_d = ST_COPY;
      ST_COPY:       if (c_fin[CMD_CP] && last_pg) state_d = ST_FLUSH;
      ST_FLUSH:      if (c_fin[CMD_FL]) state_d = ST_TLB;
      ST_TLB:        if (c_fin[CMD_TLB]) state_d = ST_DONE;
      ST_DONE:       state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      donor_q <= '0;
      rcp_q   <= '0;
      n_q     <= '0;
      pg_q    <= '0;
      stall_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_ok) begin
        n_q  <= npages_i;
        pg_q <= '0;
      end
      if (state_q == ST_PICK_DONOR) donor_q <= max_id;
      if (state_q == ST_PICK_RCP && rcp_rsp_valid_i) rcp_q <= rcp_rsp_id_i;
      if (c_fin[CMD_CP] && !last_pg) pg_q <= pg_q + PG_W'(1);
      // release on translation done wins over a same-cycle hit
      if (c_fin[CMD_TLB])            stall_q <= 1'b0;
      else if (wr_hit_i && ro_window) stall_q <= 1'b1;
    end
  end

  assign rcp_req_valid_o = (state_q == ST_PICK_RCP);
  assign rcp_req_donor_o = donor_q;
  assign ro_valid_o      = c_vld[CMD_RO];
  assign cp_valid_o      = c_vld[CMD_CP];
  assign fl_valid_o      = c_vld[CMD_FL];
  assign tlb_valid_o     = c_vld[CMD_TLB];
  assign cp_page_o       = pg_q;
  assign cmd_donor_o     = donor_q;
  assign cmd_rcp_o       = rcp_q;
  assign cmd_count_o     = n_q;
  assign stall_o         = stall_q;
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_DONE);
endmodule

// File: rtl/mig_seq_chk.sv
module mig_seq_chk #(
  parameter int PG_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_hit_i,
  input logic            rcp_req_valid_o,
  input logic            ro_valid_o,
  input logic            ro_ready_i,
  input logic            cp_valid_o,
  input logic            cp_ready_i,
  input logic            cp_done_i,
  input logic [PG_W-1:0] cp_page_o,
  input logic            fl_valid_o,
  input logic            fl_ready_i,
  input logic            tlb_valid_o,
  input logic            tlb_ready_i,
  input logic            stall_o,
  input logic            busy_o,
  input logic            done_o,
  input logic [PG_W-1:0] n_q
);
  logic            acc_q;
  logic [PG_W:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (cp_valid_o && cp_ready_i) acc_q <= 1'b1;
      else if (acc_q && cp_done_i)  acc_q <= 1'b0;
      if (done_o)                   cnt_q <= '0;
      else if (acc_q && cp_done_i)  cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rcp_req_valid_o, ro_valid_o, cp_valid_o, fl_valid_o, tlb_valid_o})); // R4
  AST_RO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ro_valid_o && !ro_ready_i |=> ro_valid_o); // R6
  AST_CP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_valid_o && !cp_ready_i |=> cp_valid_o && $stable(cp_page_o)); // R6
  AST_FL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_valid_o && !fl_ready_i |=> fl_valid_o); // R6
  AST_TLB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_valid_o && !tlb_ready_i |=> tlb_valid_o); // R6
  AST_PAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_valid_o |-> ({1'b0, cp_page_o} < {1'b0, n_q})); // R5
  AST_TLB_AFTER_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_valid_o |-> (cnt_q == {1'b0, n_q})); // R7
  AST_STALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(wr_hit_i)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R9
endmodule

bind mig_seq mig_seq_chk #(.PG_W(PG_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_hit_i        (wr_hit_i),
  .rcp_req_valid_o (rcp_req_valid_o),
  .ro_valid_o      (ro_valid_o),
  .ro_ready_i      (ro_ready_i),
  .cp_valid_o      (cp_valid_o),
  .cp_ready_i      (cp_ready_i),
  .cp_done_i       (cp_done_i),
  .cp_page_o       (cp_page_o),
  .fl_valid_o      (fl_valid_o),
  .fl_ready_i      (fl_ready_i),
  .tlb_valid_o     (tlb_valid_o),
  .tlb_ready_i     (tlb_ready_i),
  .stall_o         (stall_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .n_q             (n_q)
);

// File: tb/test_mig_seq.sv
module test_mig_seq;
  localparam int NUM_MC = 4;
  localparam int LOAD_W = 8;
  localparam int PG_W   = 4;
  localparam int ID_W   = 2;

  typedef struct packed {
    logic [31:0] ld;
    logic [7:0]  thr;
    logic [3:0]  n;
    logic [1:0]  rcp;
    logic [1:0]  dnr;
    logic        go;
  } vec_t;

  // ld[7:0] is controller 0
  localparam vec_t VEC [6] = '{
    '{32'h1E14320A, 8'd20, 4'd3, 2'd0, 2'd1, 1'b1},
    '{32'h07055A5A, 8'd10, 4'd1, 2'd2, 2'd0, 1'b1},
    '{32'h28030303, 8'd36, 4'd2, 2'd1, 2'd3, 1'b1},
    '{32'h00FF1900, 8'd0,  4'd5, 2'd3, 2'd2, 1'b1},
    '{32'h0A1E2814, 8'd30, 4'd2, 2'd1, 2'd1, 1'b0},
    '{32'h000000C8, 8'd5,  4'd0, 2'd1, 2'd0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] load_i = '0;
  logic [7:0] thresh_i = '0;
  logic [PG_W-1:0] npages_i = '0;
  logic wr_hit_i = 1'b0;
  logic rcp_req_valid_o, rcp_rsp_valid_i = 1'b0;
  logic [ID_W-1:0] rcp_req_donor_o, rcp_rsp_id_i = '0;
  logic ro_valid_o, ro_ready_i = 1'b0, ro_done_i = 1'b0;
  logic cp_valid_o, cp_ready_i = 1'b0, cp_done_i = 1'b0;
  logic [PG_W-1:0] cp_page_o;
  logic fl_valid_o, fl_ready_i = 1'b0, fl_done_i = 1'b0;
  logic tlb_valid_o, tlb_ready_i = 1'b0, tlb_done_i = 1'b0;
  logic [ID_W-1:0] cmd_donor_o, cmd_rcp_o;
  logic [PG_W-1:0] cmd_count_o;
  logic stall_o, busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  mig_seq #(.NUM_MC(NUM_MC), .LOAD_W(LOAD_W), .PG_W(PG_W)) i_mig_seq (.*);

  task automatic check(input int act, input int exp, input string msg);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  function automatic logic vld(input int p);
    case (p)
      0: return ro_valid_o;
      1: return cp_valid_o;
      2: return fl_valid_o;
      default: return tlb_valid_o;
    endcase
  endfunction

  task automatic drive(input int p, input logic r, input logic d);
    case (p)
      0: begin ro_ready_i = r; ro_done_i = d; end
      1: begin cp_ready_i = r; cp_done_i = d; end
      2: begin fl_ready_i = r; fl_done_i = d; end
      default: begin tlb_ready_i = r; tlb_done_i = d; end
    endcase
  endtask

  task automatic serve(input int p, input int page, input vec_t v, input bit slow);
    int waited = 0;
    while (!vld(p) && waited < 50) begin
      @(negedge clk_i);
      waited++;
    end
    check(int'(vld(p)), 1, $sformatf("R4 command %0d issued in order", p));
    check($countones({rcp_req_valid_o, ro_valid_o, cp_valid_o, fl_valid_o, tlb_valid_o}), 1,
          "R4 single request valid");
    check(int'(cmd_donor_o), int'(v.dnr), "R10 donor payload");
    check(int'(cmd_rcp_o), int'(v.rcp), "R10 recipient payload");
    check(int'(cmd_count_o), int'(v.n), "R10 count payload");
    if (p == 1) begin
      check(int'(cp_page_o), page, "R5 copy page index");
      check(int'(tlb_valid_o), 0, "R7 no translation update during copy");
    end
    if (slow) begin
      drive(p, 1'b0, 1'b1);
      @(negedge clk_i);
      drive(p, 1'b0, 1'b0);
      check(int'(vld(p)), 1, "R6 early done ignored, valid held");
      @(negedge clk_i);
      check(int'(vld(p)), 1, "R6 valid held without ready");
    end
    drive(p, 1'b1, 1'b0);
    @(negedge clk_i);
    drive(p, 1'b0, 1'b0);
    check(int'(vld(p)), 0, "R6 valid drops after ready");
    @(negedge clk_i);
    check(int'(busy_o), 1, "R6 waits for done");
    drive(p, 1'b0, 1'b1);
    @(negedge clk_i);
    drive(p, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(int'(busy_o), 0, "R1 reset busy");
    check(int'(done_o), 0, "R1 reset done");
    check(int'(stall_o), 0, "R1 reset stall");
    check(int'({rcp_req_valid_o, ro_valid_o, cp_valid_o, fl_valid_o, tlb_valid_o}), 0,
          "R1 reset valids");
    rst_ni = 1'b1;
    @(negedge clk_i);
    wr_hit_i = 1'b1;
    @(negedge clk_i);
    wr_hit_i = 1'b0;
    check(int'(stall_o), 0, "R8 write hit while idle ignored");

    for (int i = 0; i < 6; i++) begin
      vec_t v = VEC[i];
      load_i = v.ld;
      thresh_i = v.thr;
      npages_i = v.n;
      @(negedge clk_i);
      check(int'(busy_o), int'(v.go), $sformatf("R2 start decision vector %0d", i));
      if (!v.go) begin
        repeat (2) @(negedge clk_i);
        check(int'(busy_o | rcp_req_valid_o), 0, "R2 no migration");
        load_i = '0;
        continue;
      end
      npages_i = ~v.n;
      @(negedge clk_i);
      check(int'(rcp_req_valid_o), 1, "R3 recipient request");
      check(int'(rcp_req_donor_o), int'(v.dnr), "R3 donor choice");
      load_i = '0;
      rcp_rsp_valid_i = 1'b1;
      rcp_rsp_id_i = v.rcp;
      @(negedge clk_i);
      rcp_rsp_valid_i = 1'b0;
      rcp_rsp_id_i = ~v.rcp;
      serve(0, 0, v, i == 0);
      for (int pg = 0; pg < int'(v.n); pg++) begin
        if (i == 0 && pg == 1) begin
          wr_hit_i = 1'b1;
          @(negedge clk_i);
          wr_hit_i = 1'b0;
          check(int'(stall_o), 1, "R8 stall on write hit during copy");
        end
        serve(1, pg, v, i == 2 && pg == 1);
      end
      serve(2, 0, v, 1'b0);
      if (i == 0) check(int'(stall_o), 1, "R8 stall held through flush");
      serve(3, 0, v, 1'b0);
      check(int'(done_o), 1, "R9 done pulse");
      check(int'(busy_o), 1, "R9 busy during done");
      check(int'(stall_o), 0, "R8 stall released after translation update");
      @(negedge clk_i);
      check(int'(done_o), 0, "R9 done is one cycle");
      check(int'(busy_o), 0, "R9 back to idle");
      check(int'(cp_valid_o | tlb_valid_o), 0, "R5 no extra copy after N");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule